// File: doc/BRIEF.md
# Hashed Inverted Frame Table Translator

This block turns a process-tagged virtual address into a physical address. It uses a table that has exactly one slot per physical frame. Each slot records the owning process ID and the virtual page that currently lives in that frame. The position of the slot is the frame number, so the table stores no frame field.

A lookup folds the virtual page number and the process ID into a starting slot. From there it walks forward one slot per clock until an occupant matches or a fixed number of slots has been tried. On a hit, the slot index joins the unchanged page offset to form the physical address. A separate write port fills or clears single slots. The agent that runs page faults and replacement uses this port.

Top module: `ipt_lookup`

## Requirements
- R1: After reset, done and hit are 0, paddr is 0, lk_ready is 1, and every slot is empty, so the first lookup misses.
- R2: The page offset is lk_vaddr[12:0] and the virtual page number is lk_vaddr[31:13]. On a hit, paddr is {slot index, offset}, with the index in bits [17:13].
- R3: The first slot examined is the start slot. For each page-number bit i, bit (i mod 5) of the start slot is XORed with that bit. For each process-ID bit j, bit (j mod 5) is XORed with that bit in the same way.
- R4: A slot matches only when it is valid and both its stored process ID and its stored page number equal the request. The reported frame is the slot's index.
- R5: One slot is examined per clock, in the order start, start+1, and so on. A match on the k-th examined slot (k counted from 1) raises done k clock edges after the accepting edge.
- R6: If none of the first 8 slots examined match, the lookup ends as a miss. done then rises 8 edges after acceptance, with hit 0 and paddr 0. A match on exactly the 8th slot is still a hit.
- R7: A slot written with wr_valid=0 never matches, whatever it stores.
- R8: While wr_en is high, lk_ready is low and no lookup is accepted. Each cycle with wr_en high during a lookup delays that lookup's result by one cycle.
- R9: Slot indices wrap from 31 to 0 during probing.
- R10: lk_ready is high only while no lookup is in progress. lk_valid, lk_pid and lk_vaddr are ignored while a lookup is in progress.
- R11: done is high for a single cycle per lookup. hit and paddr hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup is accepted on an edge where lk_valid and lk_ready are both high |
| lk_pid | input | 8 | Requesting process ID |
| lk_vaddr | input | 32 | Virtual address |
| wr_en | input | 1 | Write one slot |
| wr_frame | input | 5 | Slot (frame) index to write |
| wr_pid | input | 8 | Process ID stored in the slot |
| wr_vpn | input | 19 | Page number stored in the slot |
| wr_valid | input | 1 | Valid bit stored in the slot |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Result of the last finished lookup |
| paddr | output | 18 | Physical address of the last hit, or 0 after a miss |

## Verification
Every result is due a fixed number of edges after the accepting edge. That number is k for a match on the k-th examined slot and 8 for a miss, plus one for each write cycle that overlaps the lookup. A write takes effect on the edge that samples it, and lk_ready follows wr_en within the same cycle. The bench's reference model steps on every rising edge with the same sampled inputs. Outputs are compared one nanosecond after each falling edge, so no comparison races an update. The directed lookups also count edges from acceptance to done and compare that count with the latency expected from R5, R6 and R8.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_PROBE = 1'b1
    } phase_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int VPN_W = 19,
    parameter int PID_W = 8,
    parameter int IDX_W = 5
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic [IDX_W-1:0] slot
);
    // Fold every bit of page number and process ID onto bit (i mod IDX_W).
    always_comb begin
        slot = '0;
        for (int i = 0; i < VPN_W; i++) begin
            slot = slot ^ (IDX_W'(vpn[i]) << (i % IDX_W));
        end
        for (int j = 0; j < PID_W; j++) begin
            slot = slot ^ (IDX_W'(pid[j]) << (j % IDX_W));
        end
    end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
    parameter int IDX_W = 5,
    parameter int PID_W = 8,
    parameter int VPN_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PID_W-1:0] rd_pid,
    output logic [VPN_W-1:0] rd_vpn
);
    localparam int NSLOT = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
    } slot_t;

    slot_t slot_q [NSLOT];
    slot_t slot_d [NSLOT];

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_d[s] = slot_q[s];
        end
        if (wr_en) begin
            slot_d[wr_idx].valid = wr_valid;
            slot_d[wr_idx].pid   = wr_pid;
            slot_d[wr_idx].vpn   = wr_vpn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                slot_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                slot_q[s] <= slot_d[s];
            end
        end
    end

    assign rd_valid = slot_q[rd_idx].valid;
    assign rd_pid   = slot_q[rd_idx].pid;
    assign rd_vpn   = slot_q[rd_idx].vpn;
endmodule

// File: rtl/ipt_probe.sv
module ipt_probe
    import ipt_pkg::*;
#(
    parameter int IDX_W       = 5,
    parameter int PID_W       = 8,
    parameter int VPN_W       = 19,
    parameter int OFF_W       = 13,
    parameter int PROBE_LIMIT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [PID_W-1:0]       lk_pid,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [OFF_W-1:0]       lk_off,
    input  logic [IDX_W-1:0]       start_slot,
    input  logic                   wr_en,
    output logic [IDX_W-1:0]       rd_idx,
    input  logic                   rd_valid,
    input  logic [PID_W-1:0]       rd_pid,
    input  logic [VPN_W-1:0]       rd_vpn,
    output logic                   lk_ready,
    output logic                   done,
    output logic                   hit,
    output logic [IDX_W+OFF_W-1:0] paddr
);
    localparam int PA_W  = IDX_W + OFF_W;
    localparam int CNT_W = $clog2(PROBE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROBE_LIMIT - 1);

    typedef struct packed {
        phase_e            ph;
        logic [PID_W-1:0]  pid;
        logic [VPN_W-1:0]  vpn;
        logic [OFF_W-1:0]  off;
        logic [IDX_W-1:0]  slot;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              hit;
        logic [PA_W-1:0]   pa;
    } st_t;

    st_t st_q, st_d;
    logic match;

    assign lk_ready = (st_q.ph == PH_IDLE) && !wr_en;
    assign match    = rd_valid && (rd_pid == st_q.pid) && (rd_vpn == st_q.vpn);
    assign rd_idx   = st_q.slot;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (lk_valid && lk_ready) begin
                    st_d.ph   = PH_PROBE;
                    st_d.pid  = lk_pid;
                    st_d.vpn  = lk_vpn;
                    st_d.off  = lk_off;
                    st_d.slot = start_slot;
                    st_d.cnt  = '0;
                end
            end
            PH_PROBE: begin
                // a write owns the cycle: the probe holds its place
                if (!wr_en) begin
                    if (match) begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                        st_d.hit  = 1'b1;
                        st_d.pa   = {st_q.slot, st_q.off};
                    end else if (st_q.cnt == LAST) begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                        st_d.hit  = 1'b0;
                        st_d.pa   = '0;
                    end else begin
                        st_d.slot = st_q.slot + 1'b1;
                        st_d.cnt  = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done  = st_q.done;
    assign hit   = st_q.hit;
    assign paddr = st_q.pa;
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
    parameter int IDX_W       = 5,
    parameter int PID_W       = 8,
    parameter int VPN_W       = 19,
    parameter int OFF_W       = 13,
    parameter int PROBE_LIMIT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    output logic                   lk_ready,
    input  logic [PID_W-1:0]       lk_pid,
    input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_frame,
    input  logic [PID_W-1:0]       wr_pid,
    input  logic [VPN_W-1:0]       wr_vpn,
    input  logic                   wr_valid,
    output logic                   done,
    output logic                   hit,
    output logic [IDX_W+OFF_W-1:0] paddr
);
    localparam int PA_W = IDX_W + OFF_W;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] start_slot;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_valid;
    logic [PID_W-1:0] rd_pid;
    logic [VPN_W-1:0] rd_vpn;

    assign req_off = lk_vaddr[OFF_W-1:0];
    assign req_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];

    ipt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_hash (
        .vpn  (req_vpn),
        .pid  (lk_pid),
        .slot (start_slot)
    );

    ipt_table #(.IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_frame),
        .wr_pid   (wr_pid),
        .wr_vpn   (wr_vpn),
        .wr_valid (wr_valid),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_pid   (rd_pid),
        .rd_vpn   (rd_vpn)
    );

    ipt_probe #(
        .IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W),
        .OFF_W(OFF_W), .PROBE_LIMIT(PROBE_LIMIT)
    ) u_probe (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_pid     (lk_pid),
        .lk_vpn     (req_vpn),
        .lk_off     (req_off),
        .start_slot (start_slot),
        .wr_en      (wr_en),
        .rd_idx     (rd_idx),
        .rd_valid   (rd_valid),
        .rd_pid     (rd_pid),
        .rd_vpn     (rd_vpn),
        .lk_ready   (lk_ready),
        .done       (done),
        .hit        (hit),
        .paddr      (paddr)
    );

    logic unused_pa;
    assign unused_pa = (PA_W == 0);
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
    parameter int PA_W        = 18,
    parameter int PROBE_LIMIT = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_ready,
    input logic            wr_en,
    input logic            done,
    input logic            hit,
    input logic [PA_W-1:0] paddr
);
    // Counts examining cycles (busy and not stalled) since the last acceptance.
    logic [15:0] probe_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            probe_cnt <= '0;
        end else if (lk_valid && lk_ready) begin
            probe_cnt <= '0;
        end else if (!lk_ready && !wr_en && probe_cnt != 16'hFFFF) begin
            probe_cnt <= probe_cnt + 16'd1;
        end
    end

    AST_PROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(probe_cnt) <= PROBE_LIMIT); // R6

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (paddr == '0)); // R6

    AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !lk_ready); // R8

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !lk_ready); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(hit) || done)); // R11
endmodule

bind ipt_lookup ipt_lookup_chk #(.PA_W(PA_W), .PROBE_LIMIT(PROBE_LIMIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .wr_en    (wr_en),
    .done     (done),
    .hit      (hit),
    .paddr    (paddr)
);

// File: tb/ipt_lookup_test.sv
module ipt_lookup_test;
    localparam int NF  = 32;
    localparam int OFF = 13;
    localparam int LIM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [7:0]  lk_pid = '0;
    logic [31:0] lk_vaddr = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_frame = '0;
    logic [7:0]  wr_pid = '0;
    logic [18:0] wr_vpn = '0;
    logic        wr_valid = 1'b0;
    logic        done, hit;
    logic [17:0] paddr;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 0;

    always #5 clk = ~clk;

    ipt_lookup uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_pid(lk_pid), .lk_vaddr(lk_vaddr), .wr_en(wr_en), .wr_frame(wr_frame),
        .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_valid(wr_valid),
        .done(done), .hit(hit), .paddr(paddr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int hashf(input int pid, input int vpn);
        int h = 0;
        for (int i = 0; i < 19; i++) if (((vpn >> i) & 1) != 0) h = h ^ (1 << (i % 5));
        for (int j = 0; j < 8; j++)  if (((pid >> j) & 1) != 0) h = h ^ (1 << (j % 5));
        return h;
    endfunction

    // Behavioural reference model, stepped on every rising edge.
    int tv [NF];
    int tp [NF];
    int tq [NF];
    int m_busy, m_n, m_start, m_pid, m_vpn, m_off, m_done, m_hit, m_pa;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_hit = 0; m_pa = 0; m_n = 0;
            for (int f = 0; f < NF; f++) begin tv[f] = 0; tp[f] = 0; tq[f] = 0; end
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                if (!wr_en) begin
                    int idx;
                    idx = (m_start + m_n) % NF;
                    if (tv[idx] != 0 && tp[idx] == m_pid && tq[idx] == m_vpn) begin
                        m_done = 1; m_hit = 1; m_pa = (idx << OFF) | m_off; m_busy = 0;
                    end else if (m_n == LIM - 1) begin
                        m_done = 1; m_hit = 0; m_pa = 0; m_busy = 0;
                    end else begin
                        m_n++;
                    end
                end
            end else if (lk_valid && !wr_en) begin
                m_busy  = 1;
                m_n     = 0;
                m_pid   = int'(lk_pid);
                m_vpn   = int'(lk_vaddr[31:13]);
                m_off   = int'(lk_vaddr[12:0]);
                m_start = hashf(m_pid, m_vpn);
            end
            if (wr_en) begin
                tv[int'(wr_frame)] = int'(wr_valid);
                tp[int'(wr_frame)] = int'(wr_pid);
                tq[int'(wr_frame)] = int'(wr_vpn);
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            #1;
            chk(int'(lk_ready) == ((m_busy == 0 && !wr_en) ? 1 : 0), "R10 ready",
                int'(lk_ready), (m_busy == 0 && !wr_en) ? 1 : 0);
            chk(int'(done) == m_done, "R5 done", int'(done), m_done);
            chk(int'(hit) == m_hit, "R4 hit", int'(hit), m_hit);
            chk(int'(paddr) == m_pa, "R2 paddr", int'(paddr), m_pa);
        end
    end

    task automatic write_slot(input int f, input int pid, input int vpn, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_frame = 5'(f); wr_pid = 8'(pid); wr_vpn = 19'(vpn); wr_valid = v[0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Present a request and return after the accepting rising edge.
    task automatic issue(input int pid, input int va);
        @(negedge clk);
        lk_valid = 1'b1; lk_pid = 8'(pid); lk_vaddr = 32'(va);
        #1;
        while (!lk_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic wait_done(inout int lat);
        #1;
        while (!done && lat < 40) begin @(negedge clk); #1; lat++; end
    endtask

    task automatic lookup(input int pid, input int vpn, input int off, input int exp_lat,
                          input int exp_hit, input int exp_frame, input string tag);
        int lat;
        issue(pid, (vpn << OFF) | off);
        @(negedge clk);
        lk_valid = 1'b0;
        lat = 0;
        wait_done(lat);
        chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        chk(int'(hit) == exp_hit, {tag, " hit"}, int'(hit), exp_hit);
        if (exp_hit != 0)
            chk(int'(paddr) == ((exp_frame << OFF) | off), {tag, " paddr"},
                int'(paddr), (exp_frame << OFF) | off);
        else
            chk(int'(paddr) == 0, {tag, " paddr"}, int'(paddr), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int pa_id, va, hb, hd, vc, lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(hit == 1'b0, "R1 hit", int'(hit), 0);
        chk(paddr == '0, "R1 paddr", int'(paddr), 0);
        chk(lk_ready == 1'b1, "R1 ready", int'(lk_ready), 1);
        cmp_en = 1;

        // R1 / R6: empty table misses after the full probe budget
        lookup(3, 19'h12345, 13'h0abc, LIM, 0, 0, "R1 empty miss");

        // R3 / R4: entry at the hashed slot hits on the first probe
        pa_id = hashf(3, 19'h12345);
        write_slot(pa_id, 3, 19'h12345, 1);
        lookup(3, 19'h12345, 13'h1f0f, 1, 1, pa_id, "R3 first slot");

        // R11: result held with done low
        repeat (3) begin
            @(negedge clk); #1;
            chk(done == 1'b0, "R11 done low", int'(done), 0);
            chk(hit == 1'b1, "R11 hit held", int'(hit), 1);
        end

        // R4: wrong process ID does not match
        lookup(4, 19'h12345, 0, LIM, 0, 0, "R4 pid mismatch");

        // R7: invalidated slot never matches
        write_slot(pa_id, 3, 19'h12345, 0);
        lookup(3, 19'h12345, 5, LIM, 0, 0, "R7 invalid");

        // R5: third examined slot matches after decoys
        hb = hashf(7, 19'h00abc);
        write_slot(hb, 8, 19'h00abc, 1);
        write_slot((hb + 1) % NF, 7, 19'h00abd, 1);
        write_slot((hb + 2) % NF, 7, 19'h00abc, 1);
        lookup(7, 19'h00abc, 13'h0123, 3, 1, (hb + 2) % NF, "R5 third slot");

        // R8: write blocks acceptance and stalls the probe
        @(negedge clk);
        lk_valid = 1'b1; lk_pid = 8'd7; lk_vaddr = (32'h00abc << OFF) | 32'h0042;
        wr_en = 1'b1; wr_frame = 5'((hb + 16) % NF); wr_pid = 8'hee; wr_vpn = 19'h7; wr_valid = 1'b1;
        #1;
        chk(lk_ready == 1'b0, "R8 ready low under write", int'(lk_ready), 0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(lk_ready == 1'b1, "R8 ready back", int'(lk_ready), 1);
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; wr_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        lat = 2;
        wait_done(lat);
        chk(lat == 5, "R8 stalled latency", lat, 5);
        chk(int'(paddr) == ((((hb + 2) % NF) << OFF) | 'h42), "R8 paddr",
            int'(paddr), (((hb + 2) % NF) << OFF) | 'h42);

        // R10: request inputs ignored while busy
        issue(7, (19'h00abc << OFF) | 13'h0777);
        @(negedge clk);
        lk_pid = 8'h55; lk_vaddr = 32'hdeadbeef;
        #1;
        chk(lk_ready == 1'b0, "R10 busy ready low", int'(lk_ready), 0);
        @(negedge clk);
        lk_valid = 1'b0;
        lat = 1;
        wait_done(lat);
        chk(lat == 3, "R10 latency unchanged", lat, 3);
        chk(int'(paddr) == ((((hb + 2) % NF) << OFF) | 'h777), "R10 paddr",
            int'(paddr), (((hb + 2) % NF) << OFF) | 'h777);

        // R9: wrap from slot 31 to 0
        vc = 0;
        while (hashf(5, vc) != 31) vc++;
        write_slot(31, 6, vc, 1);
        write_slot(0, 5, vc ^ 1, 1);
        write_slot(1, 5, vc, 1);
        lookup(5, vc, 13'h0011, 3, 1, 1, "R9 wrap");

        // R6: match just beyond the limit misses, at the limit hits
        hd = hashf(9, 19'h3c3c3);
        for (int k = 0; k < LIM; k++) write_slot((hd + k) % NF, 0, 0, 0);
        write_slot((hd + LIM) % NF, 9, 19'h3c3c3, 1);
        lookup(9, 19'h3c3c3, 1, LIM, 0, 0, "R6 beyond limit");
        write_slot((hd + LIM - 1) % NF, 9, 19'h3c3c3, 1);
        lookup(9, 19'h3c3c3, 2, LIM, 1, (hd + LIM - 1) % NF, "R6 last slot");

        va = 0;
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails + va);
        $finish;
    end
endmodule